// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block is the host-side engine that erases one block of a parallel NAND flash device. Software or a higher-level controller gives it a row address and a one-cycle start pulse. The block then drives the flash bus through a guarded two-command erase: a setup command, the row address bytes, and a confirm command. The page bits of the row address are always forced to zero, so the erase targets the first page of the chosen block. The two-command form protects the array against a stray write being taken as an erase.

After the confirm command, the sequencer lets a short guard interval pass. It then waits for the ready/busy line to return high, issues a status command and reads the status byte. If the byte still shows the device as not ready, it keeps reading. When the ready bit is set, it takes the pass/fail bit as the result and pulses `done`. A timeout counter, started at the confirm command, ends the operation with a timeout flag if the device never becomes ready.

Every command, address and read cycle holds its strobe low for a set number of clocks. The strobe then goes high for at least a set number of clocks. The address and command latch lines and the data byte stay stable through the whole cycle.

Top module: `nand_erase_seq`

## Requirements
- R1: While reset is high and after it is released, the bus is idle: `we_n`, `re_n` and `ce_n` are 1, `cle`, `ale` and `io_oe` are 0, and `busy`, `done`, `fail` and `timeout` are 0.
- R2: A start pulse in idle produces, in this order, a command cycle with byte 0x60 (`cle`=1, `ale`=0), exactly ROW_CYC address cycles (`ale`=1, `cle`=0), then a command cycle with byte 0xD0. `cle` and `ale` are never high together.
- R3: The address bytes are sent least significant byte first (bits 7:0, then 15:8, then 23:16). Bits [PAGE_W-1:0] of the row address are sent as zero, and all other bits are sent unchanged.
- R4: In every write cycle `we_n` stays low for exactly WE_LOW clocks, and in every read cycle `re_n` stays low for exactly WE_LOW clocks. Each low pulse is preceded by at least WE_HIGH high clocks. The two strobes are never low together.
- R5: After the confirm cycle, no status command is issued until GUARD_CLK clocks have passed and the synchronized `rb_n` reads high.
- R6: Once ready is seen, the block issues one command cycle with byte 0x70 and then read cycles. It repeats the read while status bit 6 (ready) is 0. On a read with bit 6 set to 1, status bit 0 becomes `fail` (1 = erase failed), and the byte appears on `status_last`.
- R7: `done` is high for exactly one clock at the end of each operation. `busy` falls with it, and `fail`, `timeout` and `status_last` hold until the next accepted start.
- R8: If ready is not found within TIMEOUT_CLK clocks of the confirm cycle, the operation ends with `timeout`=1 and `fail`=0. If the wait was on `rb_n`, no status command is issued.
- R9: A start pulse while `busy` is 1 is ignored. The running erase keeps its address, and no second sequence follows it.
- R10: `ce_n` is 0 exactly while `busy` is 1. `io_oe` is 1 during every write cycle and 0 during every read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to erase the block at `row_addr` |
| row_addr | input | 8*ROW_CYC | Row address (plane, block and page bits) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| fail | output | 1 | Device reported erase failure |
| timeout | output | 1 | Ready never returned within the limit |
| status_last | output | 8 | Status byte from the final read |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Byte driven onto the I/O lines |
| io_oe | output | 1 | Output enable for `io_out` |
| io_in | input | 8 | Byte read from the I/O lines |
| rb_n | input | 1 | Ready/busy from the device, low while busy |

## Verification
The bench targets the page-bit mask with row addresses whose low bits are all ones. A design that failed to clear those bits would send a nonzero first address byte, and a design that sent the bytes in the wrong order would show a byte mismatch. A responder that keeps reporting not-ready in the status byte while `rb_n` is already high checks the polling loop. A design that trusted `rb_n` alone would return after one read with the wrong result. A device that stays busy past the limit checks the timeout path, which must end without a status command and without raising `fail`. A device that is never busy checks that the guard interval does not hang the sequencer. A start pulse in the middle of an erase must neither change the address being sent nor queue a second erase.

// File: rtl/nes_pkg.sv
package nes_pkg;

  localparam logic [7:0] CMD_ERASE_SETUP   = 8'h60;
  localparam logic [7:0] CMD_ERASE_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_STATUS        = 8'h70;

  localparam int STAT_RDY_BIT  = 6;
  localparam int STAT_FAIL_BIT = 0;

  typedef enum logic [1:0] {
    BK_CMD  = 2'd0,
    BK_ADDR = 2'd1,
    BK_READ = 2'd2
  } bus_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_SETUP  = 4'd1,
    ST_ADDR   = 4'd2,
    ST_CONF   = 4'd3,
    ST_GUARD  = 4'd4,
    ST_WAITRB = 4'd5,
    ST_STCMD  = 4'd6,
    ST_STRD   = 4'd7,
    ST_CHECK  = 4'd8
  } seq_state_e;

endpackage

// File: rtl/nes_sync.sv
module nes_sync #(
  parameter int  STAGES    = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nes_timer.sv
module nes_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (en && !expired) begin
      if (cnt == CW'(LIMIT - 1)) expired <= 1'b1;
      else cnt <= cnt + 1'b1;
    end
  end

  // R8: once raised, the timeout stays until cleared
  a_r8_timer_sticky: assert property (@(posedge clk) disable iff (rst)
    (expired && !clr) |=> expired);
endmodule

// File: rtl/nes_strobe.sv
module nes_strobe
  import nes_pkg::*;
#(
  parameter int LOW_CLK  = 2,
  parameter int HIGH_CLK = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  bus_kind_e  kind,
  input  logic [7:0] wbyte,
  output logic       fin,
  output logic [7:0] rd_data,
  output logic       cle,
  output logic       ale,
  output logic       we_n,
  output logic       re_n,
  output logic [7:0] io_out,
  output logic       io_oe,
  input  logic [7:0] io_in
);
  localparam int MAXC = (LOW_CLK > HIGH_CLK) ? LOW_CLK : HIGH_CLK;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;
  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          is_read;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      is_read <= 1'b0;
      fin     <= 1'b0;
      rd_data <= '0;
      cle     <= 1'b0;
      ale     <= 1'b0;
      we_n    <= 1'b1;
      re_n    <= 1'b1;
      io_out  <= '0;
      io_oe   <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (ph)
        PH_IDLE: if (req) begin
          ph      <= PH_LOW;
          cnt     <= CW'(LOW_CLK - 1);
          is_read <= (kind == BK_READ);
          cle     <= (kind == BK_CMD);
          ale     <= (kind == BK_ADDR);
          we_n    <= (kind == BK_READ);
          re_n    <= (kind != BK_READ);
          io_oe   <= (kind != BK_READ);
          io_out  <= (kind == BK_READ) ? 8'h00 : wbyte;
        end
        PH_LOW: begin
          if (cnt == '0) begin
            ph   <= PH_HIGH;
            cnt  <= CW'(HIGH_CLK - 1);
            we_n <= 1'b1;
            re_n <= 1'b1;
            if (is_read) rd_data <= io_in;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt == '0) begin
            ph    <= PH_IDLE;
            cle   <= 1'b0;
            ale   <= 1'b0;
            io_oe <= 1'b0;
            fin   <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R4: never both strobes low
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));
  // R2: latch lines are exclusive
  a_r2_latch_excl: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));
  // R4: a cycle ends with both strobes released
  a_r4_fin_released: assert property (@(posedge clk) disable iff (rst)
    fin |-> (we_n && re_n));
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nes_pkg::*;
#(
  parameter int ROW_CYC     = 3,
  parameter int PAGE_W      = 6,
  parameter int WE_LOW      = 2,
  parameter int WE_HIGH     = 2,
  parameter int GUARD_CLK   = 4,
  parameter int TIMEOUT_CLK = 1000000,
  parameter int SYNC_STAGES = 2,
  localparam int ROW_W      = 8 * ROW_CYC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ROW_W-1:0] row_addr,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             timeout,
  output logic [7:0]       status_last,
  output logic             ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       io_out,
  output logic             io_oe,
  input  logic [7:0]       io_in,
  input  logic             rb_n
);
  localparam int IDX_W = (ROW_CYC > 1) ? $clog2(ROW_CYC) : 1;
  localparam int GW    = $clog2(GUARD_CLK + 1);
  localparam logic [ROW_W-1:0] PAGE_MASK = ROW_W'((64'd1 << PAGE_W) - 64'd1);

  seq_state_e       st;
  logic [ROW_W-1:0] row_q;
  logic [IDX_W-1:0] addr_idx;
  logic [GW-1:0]    gcnt;
  logic             pend;
  logic             rb_s;

  logic       bus_req;
  bus_kind_e  bus_kind;
  logic [7:0] bus_byte;
  logic       bus_fin;
  logic [7:0] bus_rd;
  logic       tmr_clr;
  logic       tmr_en;
  logic       tmr_exp;
  logic       in_bus_state;

  nes_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rb_sync (
    .clk(clk), .rst(rst), .d(rb_n), .q(rb_s)
  );

  nes_timer #(.LIMIT(TIMEOUT_CLK)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .en(tmr_en), .expired(tmr_exp)
  );

  nes_strobe #(.LOW_CLK(WE_LOW), .HIGH_CLK(WE_HIGH)) u_strobe (
    .clk(clk), .rst(rst), .req(bus_req), .kind(bus_kind), .wbyte(bus_byte),
    .fin(bus_fin), .rd_data(bus_rd), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  always_comb begin
    in_bus_state = 1'b0;
    bus_kind     = BK_CMD;
    bus_byte     = 8'h00;
    case (st)
      ST_SETUP: begin in_bus_state = 1'b1; bus_byte = CMD_ERASE_SETUP; end
      ST_ADDR: begin
        in_bus_state = 1'b1;
        bus_kind     = BK_ADDR;
        bus_byte     = row_q[8*addr_idx +: 8];
      end
      ST_CONF:  begin in_bus_state = 1'b1; bus_byte = CMD_ERASE_CONFIRM; end
      ST_STCMD: begin in_bus_state = 1'b1; bus_byte = CMD_STATUS; end
      ST_STRD:  begin in_bus_state = 1'b1; bus_kind = BK_READ; end
      default: ;
    endcase
  end

  assign bus_req = in_bus_state && !pend;
  assign tmr_clr = (st == ST_IDLE) && start;
  assign tmr_en  = (st == ST_GUARD) || (st == ST_WAITRB) || (st == ST_STCMD) ||
                   (st == ST_STRD)  || (st == ST_CHECK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      row_q       <= '0;
      addr_idx    <= '0;
      gcnt        <= '0;
      pend        <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      fail        <= 1'b0;
      timeout     <= 1'b0;
      status_last <= '0;
      ce_n        <= 1'b1;
    end else begin
      done <= 1'b0;
      if (bus_req) pend <= 1'b1;
      case (st)
        ST_IDLE: if (start) begin
          row_q       <= row_addr & ~PAGE_MASK;
          addr_idx    <= '0;
          busy        <= 1'b1;
          ce_n        <= 1'b0;
          fail        <= 1'b0;
          timeout     <= 1'b0;
          status_last <= '0;
          st          <= ST_SETUP;
        end
        ST_SETUP: if (bus_fin) begin pend <= 1'b0; st <= ST_ADDR; end
        ST_ADDR: if (bus_fin) begin
          pend <= 1'b0;
          if (addr_idx == IDX_W'(ROW_CYC - 1)) st <= ST_CONF;
          else addr_idx <= addr_idx + 1'b1;
        end
        ST_CONF: if (bus_fin) begin
          pend <= 1'b0;
          gcnt <= GW'(GUARD_CLK - 1);
          st   <= ST_GUARD;
        end
        ST_GUARD: begin
          if (gcnt == '0) st <= ST_WAITRB;
          else gcnt <= gcnt - 1'b1;
        end
        ST_WAITRB: begin
          if (tmr_exp) begin
            timeout <= 1'b1;
            busy    <= 1'b0;
            ce_n    <= 1'b1;
            done    <= 1'b1;
            st      <= ST_IDLE;
          end else if (rb_s) begin
            st <= ST_STCMD;
          end
        end
        ST_STCMD: if (bus_fin) begin pend <= 1'b0; st <= ST_STRD; end
        ST_STRD: if (bus_fin) begin
          pend        <= 1'b0;
          status_last <= bus_rd;
          st          <= ST_CHECK;
        end
        ST_CHECK: begin
          if (status_last[STAT_RDY_BIT]) begin
            fail <= status_last[STAT_FAIL_BIT];
            busy <= 1'b0;
            ce_n <= 1'b1;
            done <= 1'b1;
            st   <= ST_IDLE;
          end else if (tmr_exp) begin
            timeout <= 1'b1;
            busy    <= 1'b0;
            ce_n    <= 1'b1;
            done    <= 1'b1;
            st      <= ST_IDLE;
          end else begin
            st <= ST_STRD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: the first address byte carries no page bits (PAGE_W <= 8 assumed)
  a_r3_page_zero: assert property (@(posedge clk) disable iff (rst)
    (ale && !we_n && addr_idx == '0 && st == ST_ADDR) |-> (io_out & 8'(PAGE_MASK)) == 8'h00);
  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: busy only rises in answer to start
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  // R8: timeout and fail never reported together
  a_r8_tmo_not_fail: assert property (@(posedge clk) disable iff (rst)
    done |-> !(timeout && fail));
  // R5: status command only goes out when ready is seen
  a_r5_status_after_ready: assert property (@(posedge clk) disable iff (rst)
    (cle && !we_n && io_out == CMD_STATUS) |-> rb_s);
endmodule

// File: tb/nand_erase_seq_bench.sv
`timescale 1ns/1ps
module nand_erase_seq_bench;
  localparam int ROW_CYC = 3;
  localparam int PAGE_W  = 6;
  localparam int WE_LOW  = 2;
  localparam int WE_HIGH = 2;
  localparam int GUARD   = 3;
  localparam int TMO     = 400;
  localparam int ROW_W   = 8 * ROW_CYC;

  typedef struct packed {
    logic [23:0] row;
    logic [15:0] busy_len;
    logic [3:0]  nbusy;
    logic        dev_fail;
    logic        exp_tmo;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{24'h12347F, 16'd50,   4'd0, 1'b0, 1'b0},
    '{24'hFFFFFF, 16'd80,   4'd0, 1'b1, 1'b0},
    '{24'h00003F, 16'd10,   4'd3, 1'b0, 1'b0},
    '{24'hA55AC1, 16'd2000, 4'd0, 1'b0, 1'b1},
    '{24'h018000, 16'd0,    4'd1, 1'b1, 1'b0},
    '{24'h7EE781, 16'd300,  4'd2, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [ROW_W-1:0] row_addr = '0;
  logic busy, done, fail, timeout, ce_n, cle, ale, we_n, re_n, io_oe;
  logic [7:0] status_last, io_out, io_in;
  logic rb_n;

  always #2.5 clk = ~clk;

  nand_erase_seq #(
    .ROW_CYC(ROW_CYC), .PAGE_W(PAGE_W), .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH),
    .GUARD_CLK(GUARD), .TIMEOUT_CLK(TMO), .SYNC_STAGES(2)
  ) u_nand_erase_seq (
    .clk(clk), .rst(rst), .start(start), .row_addr(row_addr), .busy(busy),
    .done(done), .fail(fail), .timeout(timeout), .status_last(status_last),
    .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n)
  );

  // responder configuration (written by the test flow only)
  logic        rsp_clear = 1'b0;
  logic [15:0] cfg_busy = '0;
  logic [3:0]  cfg_nbusy = '0;
  logic        cfg_fail = 1'b0;

  // responder state (written by the responder only)
  logic [7:0] cmd_log [8];
  logic [7:0] addr_log [8];
  int cmd_cnt, addr_cnt, rd_cnt, busy_left, we_err, re_err, oe_err, ce_err;
  int lo_we, lo_re, hi_we, hi_re;
  logic prev_we, prev_re, rb_q;

  assign rb_n  = rb_q;
  assign io_in = {1'b0, (rd_cnt >= int'(cfg_nbusy)) && rb_q, 5'b0, cfg_fail};

  always @(negedge clk) begin
    if (rsp_clear) begin
      cmd_cnt = 0; addr_cnt = 0; rd_cnt = 0; busy_left = 0;
      we_err = 0; re_err = 0; oe_err = 0; ce_err = 0;
      lo_we = 0; lo_re = 0; hi_we = 100; hi_re = 100;
      prev_we = 1'b1; prev_re = 1'b1; rb_q = 1'b1;
    end else begin
      if (!rb_q) begin
        busy_left = busy_left - 1;
        if (busy_left <= 0) rb_q = 1'b1;
      end
      if ((!we_n || !re_n) && ce_n) ce_err++;
      if (prev_we && !we_n && hi_we < WE_HIGH) we_err++;
      if (prev_re && !re_n && hi_re < WE_HIGH) re_err++;
      if (!prev_we && we_n) begin
        if (lo_we != WE_LOW) we_err++;
        if (!io_oe) oe_err++;
        if (cle && cmd_cnt < 8) begin
          cmd_log[cmd_cnt] = io_out;
          if (io_out == 8'hD0 && cfg_busy != 0) begin
            busy_left = int'(cfg_busy);
            rb_q = 1'b0;
          end
        end
        if (cle) cmd_cnt++;
        if (ale && addr_cnt < 8) addr_log[addr_cnt] = io_out;
        if (ale) addr_cnt++;
      end
      if (!prev_re && re_n) begin
        if (lo_re != WE_LOW) re_err++;
        if (io_oe) oe_err++;
        rd_cnt++;
      end
      if (!we_n) begin lo_we++; hi_we = 0; end else begin lo_we = 0; hi_we++; end
      if (!re_n) begin lo_re++; hi_re = 0; end else begin lo_re = 0; hi_re++; end
      prev_we = we_n;
      prev_re = re_n;
    end
  end

  int n_tests = 0;
  int n_fail  = 0;
  logic finished = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_rsp(input logic [15:0] b, input logic [3:0] nb, input logic f);
    @(posedge clk);
    cfg_busy = b; cfg_nbusy = nb; cfg_fail = f;
    rsp_clear = 1'b1;
    @(posedge clk);
    rsp_clear = 1'b0;
  endtask

  task automatic pulse_start(input logic [ROW_W-1:0] a);
    @(posedge clk);
    #1 start = 1'b1; row_addr = a;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic wait_done(output int seen);
    seen = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic check_addr(input logic [23:0] row);
    logic [23:0] m;
    m = row & ~24'((1 << PAGE_W) - 1);
    chk("R3", "address count", addr_cnt, ROW_CYC);
    for (int k = 0; k < ROW_CYC; k++)
      chk("R3", "address byte", int'(addr_log[k]), int'(m[8*k +: 8]));
  endtask

  initial begin
    int seen;
    vec_t v;
    rsp_clear = 1'b1;
    repeat (4) @(posedge clk);
    rsp_clear = 1'b0;
    @(negedge clk);
    // R1: idle levels during reset
    chk("R1", "reset bus", {we_n, re_n, ce_n, cle, ale, io_oe}, 6'b111000);
    chk("R1", "reset flags", {busy, done, fail, timeout}, 0);
    #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "idle after reset", {we_n, re_n, ce_n, cle, ale, io_oe, busy, done}, 8'b11100000);

    for (int t = 0; t < NV; t++) begin
      v = VECS[t];
      clear_rsp(v.busy_len, v.nbusy, v.dev_fail);
      pulse_start(v.row);
      @(negedge clk);
      chk("R10", "ce_n low while busy", {busy, ce_n}, 2'b10);
      wait_done(seen);
      chk("R7", "done seen", seen, 1);
      chk("R8", "timeout flag", timeout, v.exp_tmo);
      chk("R6", "fail flag", fail, v.dev_fail && !v.exp_tmo);
      chk("R2", "setup cmd", int'(cmd_log[0]), 8'h60);
      chk("R2", "confirm cmd", int'(cmd_log[1]), 8'hD0);
      check_addr(v.row);
      if (v.exp_tmo) begin
        chk("R8", "no status cmd", cmd_cnt, 2);
        chk("R8", "no reads", rd_cnt, 0);
      end else begin
        chk("R5", "status cmd", int'(cmd_log[2]), 8'h70);
        chk("R6", "command count", cmd_cnt, 3);
        chk("R6", "polled reads", rd_cnt, int'(v.nbusy) + 1);
        chk("R6", "status byte", int'(status_last), {1'b0, 1'b1, 5'b0, v.dev_fail});
      end
      chk("R4", "strobe widths", we_err + re_err, 0);
      chk("R10", "io_oe direction", oe_err, 0);
      chk("R10", "strobe with ce_n high", ce_err, 0);
      @(negedge clk);
      chk("R7", "done one cycle", {done, busy, ce_n}, 3'b001);
      repeat (5) @(negedge clk);
      chk("R7", "flags held", {fail, timeout}, {v.dev_fail && !v.exp_tmo, v.exp_tmo});
    end

    // R9: second start during an erase is ignored
    clear_rsp(16'd100, 4'd0, 1'b0);
    pulse_start(24'h3C3C3C);
    repeat (10) @(posedge clk);
    pulse_start(24'hC3C3C3);
    wait_done(seen);
    chk("R9", "first run ends", seen, 1);
    check_addr(24'h3C3C3C);
    repeat (40) @(negedge clk);
    chk("R9", "no second sequence", cmd_cnt, 3);
    chk("R9", "idle afterwards", busy, 0);

    // R1: reset mid-operation returns to idle
    clear_rsp(16'd500, 4'd0, 1'b0);
    pulse_start(24'h000100);
    repeat (6) @(posedge clk);
    #1 rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "reset mid-run", {we_n, re_n, ce_n, cle, ale, busy}, 6'b111000);
    #1 rst = 1'b0;

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule